// File: doc/BRIEF.md
# Permuted-Word Window Detector

This block takes four single-bit inputs. From them it forms two 4-bit unsigned words. The first word places the inputs in the order A, B, C, D, with A as the most significant bit. The second word places them in the order C, A, D, B, with C as the most significant bit. The block drives one output high when the sum of the two words lies strictly inside an open interval. The default interval runs from 8 to 22, with both ends excluded. The output has no register and no handshake: it follows the inputs combinationally.

The function is realised through one 8-to-1 selector. The inputs A, B and C drive its select lines, with A as the most significant select bit. Each data leg is tied to 0, 1, D or the inverse of D. An elaboration-time function evaluates the window for every select value and picks the tie for each leg, so no constant table is written out. The selector is built as a hierarchy:
- A behavioural 2-to-1 stage is the basic cell.
- Three of these cells form each 4-to-1 stage.
- Two 4-to-1 stages are merged into the 8-to-1 selector by an inverter, two AND gates and an OR gate, all keyed on the top select bit.

Under the default bounds, every leg resolves to a constant. As a result, D has no influence on the output.

Top module: `perm_sum_window`

## Requirements
- R1: out_f is 1 for every input combination whose sum {A,B,C,D} + {C,A,D,B} satisfies 8 < sum < 22. Here A is the MSB of the first word and C is the MSB of the second word.
- R2: The lower bound is excluded. A=0,B=1,C=0,D=1 gives a sum of 8, and out_f is 0. A=0,B=0,C=1,D=0 gives a sum of 10, and out_f is 1. All sums of 8 or less give 0.
- R3: The upper bound is excluded. A=1,B=0,C=1,D=0 gives a sum of 22, and out_f is 0. A=1,B=1,C=0,D=1 gives a sum of 20, and out_f is 1. All sums of 22 or more give 0.
- R4: A=1,B=0,C=0,D=1 gives 9 + 6 = 15, and out_f is 1.
- R5: With the default bounds, toggling in_d while A, B and C are held has no effect on out_f.
- R6: out_f is combinational. It reflects a new input value within the same clock phase, with no clock edge in between.
- R7: When all four inputs are known (not X or Z), out_f is known.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 1 | Bit A: MSB of the first word, top select bit |
| in_b | input | 1 | Bit B: LSB of the second word, middle select bit |
| in_c | input | 1 | Bit C: MSB of the second word, low select bit |
| in_d | input | 1 | Bit D: LSB of the first word, may feed the data legs |
| out_f | output | 1 | High when the word sum lies strictly inside the window |

## Verification
Two functions of this block can meet on the same input change: the window test at its bounds, and the way D feeds the data legs. A toggle of D is the only change that could push a sum across a bound while the select lines stay put. The bench provokes this by flipping D for every fixed A, B, C, including the select value where D moves the sum from 5 to exactly 8. It judges the result by requiring out_f to hold its value and to match the arithmetic window computed in the bench.

// File: rtl/perm_sum_pkg.sv
package perm_sum_pkg;

  typedef enum logic [1:0] {
    LEG_ZERO = 2'd0,
    LEG_ONE  = 2'd1,
    LEG_D    = 2'd2,
    LEG_NOTD = 2'd3
  } leg_tie_e;

  // Sum of the two bit-permuted words.
  function automatic int unsigned word_sum(input logic a, input logic b,
                                           input logic c, input logic d);
    logic [3:0] w_first;
    logic [3:0] w_second;
    w_first  = {a, b, c, d};
    w_second = {c, a, d, b};
    return int'(w_first) + int'(w_second);
  endfunction

  function automatic logic in_window(input int unsigned s, input int lo_excl,
                                     input int hi_excl);
    return (int'(s) > lo_excl) && (int'(s) < hi_excl);
  endfunction

  // Select value sel = {A,B,C}; choose what the leg must carry for D=0 / D=1.
  function automatic leg_tie_e leg_for(input int sel, input int lo_excl,
                                       input int hi_excl);
    logic a, b, c, f0, f1;
    a  = sel[2];
    b  = sel[1];
    c  = sel[0];
    f0 = in_window(word_sum(a, b, c, 1'b0), lo_excl, hi_excl);
    f1 = in_window(word_sum(a, b, c, 1'b1), lo_excl, hi_excl);
    if (f0 == f1) return f0 ? LEG_ONE : LEG_ZERO;
    return f1 ? LEG_D : LEG_NOTD;
  endfunction

endpackage

// File: rtl/psw_sel2.sv
module psw_sel2 #(
  parameter int WIDTH = 1
) (
  input  logic [WIDTH-1:0] d0,
  input  logic [WIDTH-1:0] d1,
  input  logic             s,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    if (s) y = d1;
    else   y = d0;
  end
endmodule

// File: rtl/psw_sel4.sv
module psw_sel4 #(
  parameter int WIDTH = 1
) (
  input  logic [3:0][WIDTH-1:0] d,
  input  logic [1:0]            s,
  output logic [WIDTH-1:0]      y
);
  logic [WIDTH-1:0] pair_lo;
  logic [WIDTH-1:0] pair_hi;

  psw_sel2 #(.WIDTH(WIDTH)) u_lo  (.d0(d[0]),   .d1(d[1]),   .s(s[0]), .y(pair_lo));
  psw_sel2 #(.WIDTH(WIDTH)) u_hi  (.d0(d[2]),   .d1(d[3]),   .s(s[0]), .y(pair_hi));
  psw_sel2 #(.WIDTH(WIDTH)) u_fin (.d0(pair_lo), .d1(pair_hi), .s(s[1]), .y(y));
endmodule

// File: rtl/psw_sel8.sv
module psw_sel8 #(
  parameter int WIDTH = 1
) (
  input  logic [7:0][WIDTH-1:0] d,
  input  logic [2:0]            s,
  output logic [WIDTH-1:0]      y
);
  logic [3:0][WIDTH-1:0] half_lo_d;
  logic [3:0][WIDTH-1:0] half_hi_d;
  logic [WIDTH-1:0]      half_lo_y;
  logic [WIDTH-1:0]      half_hi_y;
  logic                  top_n;
  logic [WIDTH-1:0]      gated_lo;
  logic [WIDTH-1:0]      gated_hi;

  assign half_lo_d = d[3:0];
  assign half_hi_d = d[7:4];

  psw_sel4 #(.WIDTH(WIDTH)) u_half_lo (.d(half_lo_d), .s(s[1:0]), .y(half_lo_y));
  psw_sel4 #(.WIDTH(WIDTH)) u_half_hi (.d(half_hi_d), .s(s[1:0]), .y(half_hi_y));

  // glue: inverter, two AND gates, one OR gate on the top select bit
  assign top_n    = ~s[2];
  assign gated_lo = half_lo_y & {WIDTH{top_n}};
  assign gated_hi = half_hi_y & {WIDTH{s[2]}};
  assign y        = gated_lo | gated_hi;
endmodule

// File: rtl/perm_sum_window.sv
module perm_sum_window #(
  parameter int LOW_EXCL  = 8,
  parameter int HIGH_EXCL = 22
) (
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  input  logic in_d,
  output logic out_f
);
  import perm_sum_pkg::*;

  localparam int SEL_W = 3;
  localparam int LEGS  = 1 << SEL_W;

  logic [LEGS-1:0][0:0] leg;
  logic [SEL_W-1:0]     sel;
  logic                 d_n;
  logic [0:0]           sel_y;

  assign sel = {in_a, in_b, in_c};
  assign d_n = ~in_d;

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    localparam leg_tie_e TIE = leg_for(i, LOW_EXCL, HIGH_EXCL);
    if (TIE == LEG_ZERO) begin : g_zero
      assign leg[i] = 1'b0;
    end else if (TIE == LEG_ONE) begin : g_one
      assign leg[i] = 1'b1;
    end else if (TIE == LEG_D) begin : g_d
      assign leg[i] = in_d;
    end else begin : g_nd
      assign leg[i] = d_n;
    end
  end

  psw_sel8 #(.WIDTH(1)) u_sel8 (.d(leg), .s(sel), .y(sel_y));

  assign out_f = sel_y[0];
endmodule

// File: rtl/perm_sum_window_chk.sv
module perm_sum_window_chk #(
  parameter int LOW_EXCL  = 8,
  parameter int HIGH_EXCL = 22
) (
  input logic in_a,
  input logic in_b,
  input logic in_c,
  input logic in_d,
  input logic out_f
);
  import perm_sum_pkg::*;

  int unsigned s_ref;

  always_comb begin
    s_ref = word_sum(in_a, in_b, in_c, in_d);
    if (!$isunknown({in_a, in_b, in_c, in_d, out_f})) begin
      a_r1_in_range: assert (!in_window(s_ref, LOW_EXCL, HIGH_EXCL) || out_f);
      a_r2_low_edge: assert (!(int'(s_ref) <= LOW_EXCL) || !out_f);
      a_r3_high_edge: assert (!(int'(s_ref) >= HIGH_EXCL) || !out_f);
      a_r4_example: assert (!({in_a, in_b, in_c, in_d} == 4'b1001) || out_f);
    end
    if (!$isunknown({in_a, in_b, in_c, in_d})) begin
      a_r7_known_out: assert (!$isunknown(out_f));
    end
  end
endmodule

bind perm_sum_window perm_sum_window_chk #(
  .LOW_EXCL(LOW_EXCL),
  .HIGH_EXCL(HIGH_EXCL)
) chk_i (
  .in_a(in_a),
  .in_b(in_b),
  .in_c(in_c),
  .in_d(in_d),
  .out_f(out_f)
);

// File: tb/perm_sum_window_tb_top.sv
module perm_sum_window_tb_top;
  logic clk;
  logic rst_n;
  logic a, b, c, d;
  logic f;
  int   n_run;
  int   n_fail;
  bit   done;

  perm_sum_window dut_i (.in_a(a), .in_b(b), .in_c(c), .in_d(d), .out_f(f));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic ref_f(input logic ia, ib, ic, id);
    int s;
    s = int'({ia, ib, ic, id}) + int'({ic, ia, id, ib});
    return (s > 8) && (s < 22);
  endfunction

  task automatic check(input string req, input logic exp);
    n_run++;
    if (f !== exp) begin
      n_fail++;
      $display("FAIL %s: abcd=%b%b%b%b out_f=%b expected=%b", req, a, b, c, d, f, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk);
    {a, b, c, d} = v;
    #1;
  endtask

  task automatic t_idle;            // R2: all zero, sum 0
    drive(4'b0000);
    check("R2 idle", 1'b0);
  endtask

  task automatic t_sweep;           // R1: every combination
    for (int v = 0; v < 16; v++) begin
      drive(v[3:0]);
      check("R1 sweep", ref_f(a, b, c, d));
    end
  endtask

  task automatic t_low_edge;        // R2
    drive(4'b0101); check("R2 sum8", 1'b0);
    drive(4'b0010); check("R2 sum10", 1'b1);
    drive(4'b0001); check("R2 sum3", 1'b0);
  endtask

  task automatic t_high_edge;       // R3
    drive(4'b1010); check("R3 sum22", 1'b0);
    drive(4'b1101); check("R3 sum20", 1'b1);
    drive(4'b1111); check("R3 sum30", 1'b0);
  endtask

  task automatic t_example;         // R4
    drive(4'b1001); check("R4 example", 1'b1);
  endtask

  task automatic t_d_blind;         // R5
    for (int s = 0; s < 8; s++) begin
      logic held;
      drive({s[2:0], 1'b0});
      held = f;
      @(negedge clk);
      d = 1'b1;
      #1;
      check("R5 d toggle", held);
    end
  endtask

  task automatic t_same_phase;      // R6: no edge between change and sample
    @(posedge clk);
    #0.5;
    {a, b, c, d} = 4'b0100;
    #0.5;
    check("R6 comb lo", 1'b0);
    {a, b, c, d} = 4'b0110;
    #0.5;
    check("R6 comb hi", 1'b1);
  endtask

  task automatic t_known;           // R7
    drive(4'b0111);
    n_run++;
    if ($isunknown(f)) begin
      n_fail++;
      $display("FAIL R7: out_f=%b expected=known", f);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    {a, b, c, d} = 4'b0000;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_sweep();
    t_low_edge();
    t_high_edge();
    t_example();
    t_d_blind();
    t_same_phase();
    t_known();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule